// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Frame Tags and Fill Status

This block is the storage stage between an HDLC deframer and a processor. The deframer offers one byte per strobe, together with an end-of-frame mark and two error marks: a frame check mismatch and an abort. The block stores each byte with a 2-bit position tag, so software can rebuild frame boundaries and see which frames ended badly. A 2-bit fill status reports empty, lightly filled, heavily filled or overflowed. The fill boundary can be selected from two settings.

Software can issue a soft flush. The status then reports empty at once, and incoming bytes are refused until the deframer reports the next flag. The stored bytes themselves are left in place. Only the read side is re-aligned, so they can no longer be read.

In transparent mode the queue stores raw bytes with no framing meaning. A write into a full queue replaces the newest entry instead of being dropped. In this mode flags are ignored, so software ends a flush by clearing it explicitly. Reads pop the oldest entry into registered data and tag outputs.

Top module: `hdlc_rxq`

## Requirements
- R1: In normal mode each stored byte gets a tag, read back on `rd_tag`. The tag is 01 for the first byte accepted after a flag, 00 for any other byte, 10 for a byte marked end-of-frame with no error, and 11 for an end-of-frame byte marked with a check mismatch or an abort.
- R2: `fifo_stat` is registered. It encodes 00 when empty, 01 when 1 up to (threshold-1) bytes are held, 11 when the threshold or more are held, and 10 while an overflow is recorded. The overflow code takes priority over the count codes.
- R3: With `alt_thresh` low the threshold is 15 bytes. With it high the threshold is 5 bytes, so 4 or fewer bytes report 01.
- R4: In normal mode, a byte offered to a full queue with no read in the same cycle is dropped. The byte count does not change and an overflow is recorded. The overflow record clears on the next flag.
- R5: In transparent mode every byte is tagged 00. A byte offered to a full queue overwrites the newest stored byte. The overflow record then stays set through any flag until a soft flush.
- R6: A `frst_set` pulse makes `fifo_stat` read 00 and raises `frst_pend` on the next edge, and clears the overflow record. While `frst_pend` is high, offered bytes are discarded. In normal mode a flag clears `frst_pend`. Bytes held before the flush are never read out.
- R7: In transparent mode a flag leaves `frst_pend` unchanged. Only a `frst_clr` pulse clears it.
- R8: A read while the queue is empty leaves `rd_data` and `rd_tag` unchanged and moves no pointer. The next byte written is the next byte read.
- R9: Bytes are read in write order. A read and a write in the same cycle on a non-empty queue leave the byte count unchanged.
- R10: After reset, `fifo_stat`, `rd_data`, `rd_tag` and `frst_pend` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| transp_en | input | 1 | Transparent mode select |
| alt_thresh | input | 1 | Selects the 5-byte fill threshold instead of 15 |
| flag_in | input | 1 | Pulse: deframer saw a flag |
| byte_vld | input | 1 | Pulse: received byte offered |
| byte_data | input | 8 | Received byte |
| byte_end | input | 1 | Offered byte ends a frame |
| end_crc_bad | input | 1 | Frame check mismatch, with `byte_end` |
| end_abort | input | 1 | Frame aborted, with `byte_end` |
| frst_set | input | 1 | Pulse: start a soft flush |
| frst_clr | input | 1 | Pulse: end a soft flush from software |
| rd_en | input | 1 | Pulse: pop oldest byte |
| rd_data | output | 8 | Last popped byte |
| rd_tag | output | 2 | Tag of last popped byte |
| fifo_stat | output | 2 | Encoded fill/overflow status |
| frst_pend | output | 1 | Soft flush in progress, reception held |

## Verification
The assertions assume that `byte_end` and its two error marks are only meaningful together with `byte_vld`. They also assume that `flag_in` never arrives in the same cycle as an offered byte, and that `frst_set` and `frst_clr` are single-cycle pulses that are never raised together. The stimulus drives every input from tasks that each raise one such pulse for exactly one cycle. The only operations it ever overlaps are a read and a write. It changes `transp_en` and `alt_thresh` only while no strobe is active.

// File: rtl/hdlc_rxq_pkg.sv
package hdlc_rxq_pkg;

  typedef enum logic [1:0] {
    TAG_MID     = 2'b00,
    TAG_FIRST   = 2'b01,
    TAG_END_OK  = 2'b10,
    TAG_END_BAD = 2'b11
  } rxq_tag_e;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_LOW   = 2'b01,
    ST_OVF   = 2'b10,
    ST_HIGH  = 2'b11
  } rxq_stat_e;

  // position tag for a byte being stored
  function automatic rxq_tag_e tag_for(input logic first, input logic last,
                                       input logic bad, input logic transp);
    if (transp) return TAG_MID;
    if (last) return bad ? TAG_END_BAD : TAG_END_OK;
    return first ? TAG_FIRST : TAG_MID;
  endfunction

  // fill status: pending flush, then overflow, then count bands
  function automatic rxq_stat_e stat_for(input int cnt, input logic ovf,
                                         input logic pend, input int hi);
    if (pend) return ST_EMPTY;
    if (ovf) return ST_OVF;
    if (cnt == 0) return ST_EMPTY;
    if (cnt < hi) return ST_LOW;
    return ST_HIGH;
  endfunction

endpackage

// File: rtl/rxq_tagger.sv
module rxq_tagger
  import hdlc_rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     transp_en,
  input  logic     flag_ok,
  input  logic     take,
  input  logic     byte_end,
  input  logic     end_bad,
  output rxq_tag_e tag
);

  logic first_q;

  assign tag = tag_for(first_q, byte_end, end_bad, transp_en);

  // a flag arms the first-byte mark; any byte taken disarms it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       first_q <= 1'b0;
    else if (flag_ok) first_q <= 1'b1;
    else if (take)    first_q <= 1'b0;
  end

  p_raw_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && transp_en) |-> (tag == TAG_MID));

  p_end_marked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && byte_end && !transp_en) |-> tag[1]);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter  int DEPTH = 19,
  parameter  int EW    = 10,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rq;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rq <= '0;
    else if (re) rq <= mem[raddr];
  end

  assign rdata = rq;

  p_waddr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (32'(waddr) < DEPTH));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rq));

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import hdlc_rxq_pkg::*;
#(
  parameter  int DEPTH     = 19,
  parameter  int HI_TH     = 15,
  parameter  int HI_TH_ALT = 5,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          transp_en,
  input  logic          alt_thresh,
  input  logic          flag_in,
  input  logic          byte_vld,
  input  logic          frst_set,
  input  logic          frst_clr,
  input  logic          rd_en,
  output logic          take,
  output logic          flag_ok,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          rd_ok,
  output logic [AW-1:0] mem_raddr,
  output rxq_stat_e     stat,
  output logic          pend
);

  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n, pend_q, pend_n;
  rxq_stat_e     stat_q, stat_n;
  logic          flag_norm, rx_on, full_blk, store_new, ovf_evt, overwrite;

  function automatic logic [AW-1:0] step_fwd(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] step_back(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  // named internal events
  assign flag_norm = flag_in && !transp_en;
  assign rx_on     = !pend_q && !frst_set;
  assign take      = byte_vld && rx_on;
  assign flag_ok   = flag_norm && !frst_set;
  assign rd_ok     = rd_en && (cnt_q != '0) && !frst_set;
  assign full_blk  = (cnt_q == CW'(DEPTH)) && !rd_ok;
  assign store_new = take && !full_blk;
  assign ovf_evt   = take && full_blk;
  assign overwrite = ovf_evt && transp_en;

  assign mem_we    = store_new || overwrite;
  assign mem_waddr = overwrite ? step_back(wp_q) : wp_q;
  assign mem_raddr = rp_q;

  always_comb begin
    wp_n   = wp_q;
    rp_n   = rp_q;
    cnt_n  = cnt_q;
    ovf_n  = ovf_q;
    pend_n = pend_q;
    if (frst_set) begin
      rp_n   = wp_q;
      cnt_n  = '0;
      ovf_n  = 1'b0;
      pend_n = 1'b1;
    end else begin
      if (store_new) wp_n = step_fwd(wp_q);
      if (rd_ok)     rp_n = step_fwd(rp_q);
      cnt_n = cnt_q + CW'(store_new) - CW'(rd_ok);
      if (ovf_evt)        ovf_n = 1'b1;
      else if (flag_norm) ovf_n = 1'b0;
      if (frst_clr || flag_norm) pend_n = 1'b0;
    end
    stat_n = stat_for(int'(cnt_n), ovf_n, pend_n, alt_thresh ? HI_TH_ALT : HI_TH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
      stat_q <= ST_EMPTY;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      cnt_q  <= cnt_n;
      ovf_q  <= ovf_n;
      pend_q <= pend_n;
      stat_q <= stat_n;
    end
  end

  assign stat = stat_q;
  assign pend = pend_q;

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= DEPTH);

  p_rw_same_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && store_new) |=> (cnt_q == $past(cnt_q)));

  p_drop_keeps_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !transp_en) |=> (cnt_q == $past(cnt_q)) && (stat_q == ST_OVF));

  p_flag_clears_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_norm && !frst_set && !ovf_evt) |=> !ovf_q);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (transp_en && ovf_q && !frst_set) |=> ovf_q);

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frst_set |=> (cnt_q == '0) && (stat_q == ST_EMPTY) && pend_q);

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cnt_q == '0 && !frst_set) |=> (rp_q == $past(rp_q)));

  p_transp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (transp_en && pend_q && !frst_clr) |=> pend_q);

endmodule

// File: rtl/hdlc_rxq.sv
module hdlc_rxq
  import hdlc_rxq_pkg::*;
#(
  parameter int DEPTH     = 19,
  parameter int DW        = 8,
  parameter int HI_TH     = 15,
  parameter int HI_TH_ALT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          transp_en,
  input  logic          alt_thresh,
  input  logic          flag_in,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          byte_end,
  input  logic          end_crc_bad,
  input  logic          end_abort,
  input  logic          frst_set,
  input  logic          frst_clr,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    rd_tag,
  output logic [1:0]    fifo_stat,
  output logic          frst_pend
);

  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 2;

  logic          take, flag_ok, mem_we, rd_ok;
  logic [AW-1:0] waddr, raddr;
  rxq_tag_e      cur_tag;
  rxq_stat_e     stat;
  logic [EW-1:0] rdata;

  rxq_ctrl #(
    .DEPTH(DEPTH), .HI_TH(HI_TH), .HI_TH_ALT(HI_TH_ALT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .transp_en(transp_en), .alt_thresh(alt_thresh),
    .flag_in(flag_in), .byte_vld(byte_vld), .frst_set(frst_set), .frst_clr(frst_clr),
    .rd_en(rd_en), .take(take), .flag_ok(flag_ok), .mem_we(mem_we),
    .mem_waddr(waddr), .rd_ok(rd_ok), .mem_raddr(raddr), .stat(stat), .pend(frst_pend)
  );

  rxq_tagger u_tag (
    .clk(clk), .rst_n(rst_n), .transp_en(transp_en), .flag_ok(flag_ok), .take(take),
    .byte_end(byte_end), .end_bad(end_crc_bad || end_abort), .tag(cur_tag)
  );

  rxq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr), .wdata({cur_tag, byte_data}),
    .re(rd_ok), .raddr(raddr), .rdata(rdata)
  );

  assign rd_data   = rdata[DW-1:0];
  assign rd_tag    = rdata[EW-1:DW];
  assign fifo_stat = stat;

  p_pend_reads_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frst_pend |-> (fifo_stat == 2'b00));

endmodule

// File: tb/tb_hdlc_rxq.sv
module tb_hdlc_rxq;
  localparam int DEPTH = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic transp_en = 0, alt_thresh = 0, flag_in = 0, byte_vld = 0;
  logic [7:0] byte_data = 0;
  logic byte_end = 0, end_crc_bad = 0, end_abort = 0;
  logic frst_set = 0, frst_clr = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic [1:0] rd_tag, fifo_stat;
  logic frst_pend;

  hdlc_rxq dut (
    .clk(clk), .rst_n(rst_n), .transp_en(transp_en), .alt_thresh(alt_thresh),
    .flag_in(flag_in), .byte_vld(byte_vld), .byte_data(byte_data), .byte_end(byte_end),
    .end_crc_bad(end_crc_bad), .end_abort(end_abort), .frst_set(frst_set),
    .frst_clr(frst_clr), .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag),
    .fifo_stat(fifo_stat), .frst_pend(frst_pend)
  );

  always #4 clk = ~clk;

  int checks = 0, errs = 0;
  bit done = 0;

  // behavioural reference
  logic [9:0] mq[$];
  logic [9:0] m_e;
  logic [7:0] m_data;
  logic [1:0] m_tag, m_t, m_stat;
  bit m_ovf, m_pend, m_first, m_flag;

  function automatic logic [1:0] exp_stat(int n, bit ovf, bit pend, bit alt);
    int hi;
    hi = alt ? 5 : 15;
    if (pend || (!ovf && n == 0)) return 2'b00;
    else if (ovf) return 2'b10;
    else return (n >= hi) ? 2'b11 : 2'b01;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_data = 0; m_tag = 0; m_ovf = 0; m_pend = 0; m_first = 0;
    end else if (frst_set) begin
      mq.delete(); m_ovf = 0; m_pend = 1;
    end else begin
      m_flag = flag_in && !transp_en;
      if (rd_en && mq.size() > 0) begin
        m_e = mq.pop_front(); m_data = m_e[7:0]; m_tag = m_e[9:8];
      end
      if (m_flag) m_ovf = 0;
      if (byte_vld && !m_pend) begin
        if (transp_en) m_t = 2'd0;
        else if (byte_end) m_t = (end_crc_bad || end_abort) ? 2'd3 : 2'd2;
        else m_t = m_first ? 2'd1 : 2'd0;
        if (mq.size() < DEPTH) mq.push_back({m_t, byte_data});
        else begin
          m_ovf = 1;
          if (transp_en) mq[mq.size()-1] = {m_t, byte_data};
        end
        m_first = 0;
      end
      if (m_flag) begin m_first = 1; m_pend = 0; end
      if (frst_clr) m_pend = 0;
    end
    m_stat = exp_stat(mq.size(), m_ovf, m_pend, alt_thresh);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 tag vs model", rd_tag, m_tag);
      chk("R9 data vs model", rd_data, m_data);
      chk("R2 status vs model", fifo_stat, m_stat);
      chk("R6 pending vs model", frst_pend, m_pend);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic put(input logic [7:0] d, input bit last = 0, input bit bad = 0, input bit abt = 0);
    byte_vld = 1; byte_data = d; byte_end = last; end_crc_bad = bad; end_abort = abt;
    tick();
    byte_vld = 0; byte_end = 0; end_crc_bad = 0; end_abort = 0;
  endtask
  task automatic flag(); flag_in = 1; tick(); flag_in = 0; endtask
  task automatic pull(); rd_en = 1; tick(); rd_en = 0; endtask
  task automatic both(input logic [7:0] d);
    rd_en = 1; byte_vld = 1; byte_data = d; tick(); rd_en = 0; byte_vld = 0;
  endtask
  task automatic fset(); frst_set = 1; tick(); frst_set = 0; endtask
  task automatic fclr(); frst_clr = 1; tick(); frst_clr = 0; endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R10 reset status", fifo_stat, 0);
    chk("R10 reset data", rd_data, 0);
    chk("R10 reset tag", rd_tag, 0);
    chk("R10 reset pending", frst_pend, 0);
    rst_n = 1;
    tick();

    // frame tagging
    flag(); put(8'h11); put(8'h22); put(8'h33, 1);
    chk("R2 low band", fifo_stat, 2'b01);
    pull(); chk("R1 first tag", rd_tag, 1); chk("R9 order", rd_data, 8'h11);
    pull(); chk("R1 middle tag", rd_tag, 0); chk("R9 order", rd_data, 8'h22);
    pull(); chk("R1 good end tag", rd_tag, 2); chk("R9 order", rd_data, 8'h33);
    flag(); put(8'h44, 1, 1); pull(); chk("R1 crc bad end tag", rd_tag, 3);
    flag(); put(8'h55, 1, 0, 1); pull(); chk("R1 abort end tag", rd_tag, 3);
    chk("R2 empty", fifo_stat, 0);

    // thresholds
    flag();
    for (int i = 0; i < 14; i++) put(8'(i));
    chk("R2 fourteen is low", fifo_stat, 2'b01);
    put(8'd14);
    chk("R2 fifteen is high", fifo_stat, 2'b11);
    alt_thresh = 1;
    for (int i = 0; i < 11; i++) pull();
    chk("R3 four is low in alt", fifo_stat, 2'b01);
    put(8'h77);
    chk("R3 five is high in alt", fifo_stat, 2'b11);
    alt_thresh = 0; tick();
    chk("R3 five is low in normal", fifo_stat, 2'b01);
    for (int i = 0; i < 5; i++) pull();
    chk("R9 last of batch", rd_data, 8'h77);

    // normal overflow
    flag();
    for (int i = 0; i < DEPTH; i++) put(8'(8'h80 + i));
    chk("R2 full is high", fifo_stat, 2'b11);
    put(8'hEE);
    chk("R4 overflow status", fifo_stat, 2'b10);
    for (int i = 0; i < DEPTH; i++) pull();
    chk("R4 dropped byte absent", rd_data, 8'h92);
    chk("R4 overflow held until flag", fifo_stat, 2'b10);
    flag();
    chk("R4 flag clears overflow", fifo_stat, 0);

    // empty read
    pull();
    chk("R8 empty read keeps data", rd_data, 8'h92);
    chk("R8 empty read status", fifo_stat, 0);
    put(8'h3C); pull();
    chk("R8 next write is next read", rd_data, 8'h3C);

    // simultaneous read and write
    put(8'h01); put(8'h02); put(8'h03);
    both(8'h04);
    chk("R9 rw returns oldest", rd_data, 8'h01);
    for (int i = 0; i < 11; i++) put(8'(8'h10 + i));
    both(8'h20);
    chk("R9 rw keeps fourteen", fifo_stat, 2'b01);
    put(8'h21);
    chk("R9 fifteen high", fifo_stat, 2'b11);
    both(8'h22);
    chk("R9 rw keeps fifteen", fifo_stat, 2'b11);
    for (int i = 0; i < 15; i++) pull();
    chk("R9 drained", fifo_stat, 0);

    // soft flush
    put(8'hA1); put(8'hA2);
    fset();
    chk("R6 flush reads empty", fifo_stat, 0);
    chk("R6 flush pending", frst_pend, 1);
    put(8'hB1);
    chk("R6 byte discarded", fifo_stat, 0);
    flag();
    chk("R6 flag ends flush", frst_pend, 0);
    put(8'hC1);
    chk("R6 receiving again", fifo_stat, 2'b01);
    pull();
    chk("R6 old bytes not read", rd_data, 8'hC1);

    // transparent mode
    transp_en = 1; tick();
    for (int i = 0; i < DEPTH; i++) put(8'(8'h40 + i), i[0], i[1]);
    put(8'hD0);
    chk("R5 overflow status", fifo_stat, 2'b10);
    put(8'hD1);
    flag();
    chk("R5 flag ignored for overflow", fifo_stat, 2'b10);
    for (int i = 0; i < DEPTH - 1; i++) pull();
    chk("R5 older bytes kept", rd_data, 8'h51);
    pull();
    chk("R5 newest overwritten", rd_data, 8'hD1);
    chk("R5 raw tag", rd_tag, 0);
    chk("R5 overflow sticky", fifo_stat, 2'b10);

    fset();
    chk("R7 flush pending", frst_pend, 1);
    flag();
    chk("R7 flag ignored", frst_pend, 1);
    put(8'h98);
    chk("R7 still discarding", fifo_stat, 0);
    fclr();
    chk("R7 software clears", frst_pend, 0);
    put(8'h99);
    chk("R7 receiving after clear", fifo_stat, 2'b01);
    pull();
    chk("R7 byte read", rd_data, 8'h99);
    transp_en = 0;
    tick(); tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule